// File: doc/BRIEF.md
# Weighted Threshold Gate with Hysteresis

This block is a parameterized M-of-N threshold gate for delay-insensitive dual-rail logic. Each of its N single-bit inputs is either NULL (0) or DATA (1) and carries an integer weight fixed at elaboration. Once the weights of the asserted inputs add up to the threshold M or more, the output goes to DATA. It stays at DATA until every input has gone back to NULL. The output then drops to NULL and stays there until the threshold is reached again.

No clock is involved. The hysteresis is a level-sensitive feedback term, next = S(x) OR (out AND R(x)). S is the threshold comparison. R is the OR of all inputs, so it depends only on how many inputs the gate has. An active-high initialisation reset forces the output to NULL. The same module covers the usual cells of such a library:
- the two-input C-element (2-of-2),
- the three-input OR (1-of-3),
- the 2-of-3 majority with hold,
- weighted forms such as 3-of-3 with one input of weight 2,
- 2-of-4 with one input of weight 2.

Top module: `thg_gate`

## Requirements
- R1: When the output is NULL and reset is low, the output goes to DATA as soon as the sum of weights of the asserted inputs is at least THRESH. The weight of input i is the WW-bit field WEIGHTS[i*WW +: WW].
- R2: Once at DATA, the output stays at DATA while at least one input is asserted, even if the weighted sum falls below THRESH.
- R3: The output goes from DATA to NULL only when all inputs are 0 (or reset is high).
- R4: While the output is NULL, it stays NULL for any input pattern whose weighted sum is below THRESH, including patterns with some inputs asserted.
- R5: While rst is 1, the output is 0 whatever the inputs are. After rst falls, the output follows R1 to R4 from the NULL state.
- R6: With N_IN=2, both weights 1 and THRESH=2, the gate acts as a C-element: it rises only when both inputs are 1 and falls only when both are 0.
- R7: With N_IN=3, all weights 1 and THRESH=1, the output always equals the OR of the inputs.
- R8: With N_IN=3, THRESH=3 and a weight of 2 on input 0, the output rises when input 0 and at least one of inputs 1 and 2 are asserted, and clears only when all three are 0.
- R9: With N_IN=3, all weights 1 and THRESH=2, the output rises when any two inputs are asserted, and holds until all three are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high initialisation; forces the output to NULL |
| din | input | N_IN | Input rails, 1 = DATA, 0 = NULL |
| dout | output | 1 | Gate output with hysteresis |

## Verification
The assertions fire on output edges and read the inputs as settled at that moment. They therefore assume that the inputs do not change again in the same instant the output switches. They also assume that reset is high and the inputs are 0 before the output first takes a value. The stimulus starts with reset high and the inputs at 0. It then applies exactly one input and reset pattern per step and waits before sampling. Random steps toggle single inputs, clear all inputs now and then, and pulse reset, so that partial arrivals, holds and releases all occur in every variant.

// File: rtl/thg_pkg.sv
package thg_pkg;

  // Width needed to hold the sum of n weights, each up to ww bits wide.
  function automatic int unsigned sum_bits(input int unsigned n, input int unsigned ww);
    int unsigned max_sum;
    max_sum = n * ((1 << ww) - 1);
    return (max_sum < 1) ? 1 : $clog2(max_sum + 1);
  endfunction

  // Set function of the gate: threshold reached.
  function automatic logic reaches(input int unsigned sum, input int unsigned thresh);
    return sum >= thresh;
  endfunction

  // Next output value from the set term, the reset term and the held value.
  function automatic logic next_out(input logic set_t, input logic any_t, input logic held);
    return set_t | (held & any_t);
  endfunction

endpackage

// File: rtl/thg_wsum.sv
module thg_wsum #(
  parameter int unsigned N_IN = 4,
  parameter int unsigned WW = 4,
  parameter logic [N_IN*WW-1:0] WEIGHTS = '0,
  parameter int unsigned SW = 6
) (
  input  logic [N_IN-1:0] din,
  output logic [SW-1:0]   wsum
);
  logic [SW-1:0] terms [N_IN];

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_term
    assign terms[gi] = din[gi] ? SW'(WEIGHTS[gi*WW +: WW]) : '0;
  end

  always_comb begin
    wsum = '0;
    for (int i = 0; i < N_IN; i++) wsum = wsum + terms[i];
  end
endmodule

// File: rtl/thg_set.sv
module thg_set #(
  parameter int unsigned SW = 6,
  parameter int unsigned THRESH = 2
) (
  input  logic [SW-1:0] wsum,
  output logic          set_hit
);
  assign set_hit = thg_pkg::reaches(int'(wsum), THRESH);
endmodule

// File: rtl/thg_hold.sv
module thg_hold (
  input  logic rst,
  input  logic set_hit,
  input  logic any_in,
  output logic q
);
  // Level-sensitive storage: transparent while the set or release condition holds.
  always_latch begin
    if (rst) q <= 1'b0;
    else if (set_hit || !any_in) q <= thg_pkg::next_out(set_hit, any_in, 1'b0);
  end
endmodule

// File: rtl/thg_gate.sv
module thg_gate #(
  parameter int unsigned N_IN = 4,
  parameter int unsigned WW = 4,
  parameter logic [N_IN*WW-1:0] WEIGHTS = 16'h1112,
  parameter int unsigned THRESH = 2
) (
  input  logic            rst,
  input  logic [N_IN-1:0] din,
  output logic            dout
);
  localparam int unsigned SW = thg_pkg::sum_bits(N_IN, WW);

  logic [SW-1:0] wsum;
  logic          set_hit;
  logic          any_in;

  assign any_in = |din;

  thg_wsum #(.N_IN(N_IN), .WW(WW), .WEIGHTS(WEIGHTS), .SW(SW)) u_wsum (
    .din(din), .wsum(wsum)
  );

  thg_set #(.SW(SW), .THRESH(THRESH)) u_set (
    .wsum(wsum), .set_hit(set_hit)
  );

  thg_hold u_hold (
    .rst(rst), .set_hit(set_hit), .any_in(any_in), .q(dout)
  );
endmodule

// File: rtl/thg_gate_chk.sv
module thg_gate_chk #(
  parameter int unsigned N_IN = 4,
  parameter int unsigned WW = 4,
  parameter logic [N_IN*WW-1:0] WEIGHTS = 16'h1112,
  parameter int unsigned THRESH = 2
) (
  input logic            rst,
  input logic [N_IN-1:0] din,
  input logic            dout,
  input logic            set_hit,
  input logic            any_in
);
  function automatic int unsigned recount(input logic [N_IN-1:0] d);
    int unsigned s;
    s = 0;
    for (int i = 0; i < N_IN; i++) if (d[i]) s += int'(WEIGHTS[i*WW +: WW]);
    return s;
  endfunction

  always @(posedge dout) begin
    AST_RISE_NEEDS_SET: assert (set_hit) else $error("rise without set term"); // R1
    AST_RISE_NEEDS_COUNT: assert (recount(din) >= THRESH) else $error("rise below threshold"); // R4
    AST_RISE_NOT_IN_RESET: assert (!rst) else $error("rise during reset"); // R5
  end

  always @(negedge dout) begin
    AST_FALL_ONLY_ON_NULL: assert (rst || !any_in) else $error("fall with input still DATA"); // R3
    AST_FALL_NOT_WHILE_SET: assert (rst || !set_hit) else $error("fall with threshold met"); // R2
  end
endmodule

bind thg_gate thg_gate_chk #(.N_IN(N_IN), .WW(WW), .WEIGHTS(WEIGHTS), .THRESH(THRESH)) u_chk (
  .rst(rst), .din(din), .dout(dout), .set_hit(set_hit), .any_in(any_in)
);

// File: tb/thg_gate_bench.sv
module thg_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] d = 4'b0000;
  logic o_main, o_c2, o_or3, o_maj, o_w33;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thg_gate u_thg_gate (.rst(rst), .din(d), .dout(o_main));
  thg_gate #(.N_IN(2), .WW(4), .WEIGHTS(8'h11), .THRESH(2)) u_c2 (.rst(rst), .din(d[1:0]), .dout(o_c2));
  thg_gate #(.N_IN(3), .WW(4), .WEIGHTS(12'h111), .THRESH(1)) u_or3 (.rst(rst), .din(d[2:0]), .dout(o_or3));
  thg_gate #(.N_IN(3), .WW(4), .WEIGHTS(12'h111), .THRESH(2)) u_maj (.rst(rst), .din(d[2:0]), .dout(o_maj));
  thg_gate #(.N_IN(3), .WW(4), .WEIGHTS(12'h112), .THRESH(3)) u_w33 (.rst(rst), .din(d[2:0]), .dout(o_w33));

  bit e_main = 0, e_c2 = 0, e_or3 = 0, e_maj = 0, e_w33 = 0;

  function automatic bit model(input int w0, w1, w2, w3, input int m,
                               input logic [3:0] x, input bit prev, input bit r);
    int s;
    s = (x[0] ? w0 : 0) + (x[1] ? w1 : 0) + (x[2] ? w2 : 0) + (x[3] ? w3 : 0);
    if (r) return 1'b0;
    if (s >= m) return 1'b1;
    if (x == 4'b0000) return 1'b0;
    return prev;
  endfunction

  task automatic check(input string tag, input string name, input logic got, input bit exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%b exp=%b din=%b rst=%b", tag, name, got, exp, d, rst);
    end
  endtask

  task automatic apply(input logic [3:0] x, input bit r);
    bit prev;
    string tag;
    d = x;
    rst = r;
    prev = e_main;
    e_main = model(2, 1, 1, 1, 2, x, e_main, r);
    e_c2 = model(1, 1, 0, 0, 2, {2'b00, x[1:0]}, e_c2, r);
    e_or3 = model(1, 1, 1, 0, 1, {1'b0, x[2:0]}, e_or3, r);
    e_maj = model(1, 1, 1, 0, 2, {1'b0, x[2:0]}, e_maj, r);
    e_w33 = model(2, 1, 1, 0, 3, {1'b0, x[2:0]}, e_w33, r);
    #(CLK_PERIOD/2);
    if (r) tag = "R5";
    else if (!prev && e_main) tag = "R1";
    else if (prev && e_main) tag = "R2";
    else if (prev && !e_main) tag = "R3";
    else tag = "R4";
    check(tag, "main", o_main, e_main);
    check("R6", "c2", o_c2, e_c2);
    check("R7", "or3", o_or3, e_or3);
    check("R7", "or3_vs_or", o_or3, bit'(|x[2:0]) & !r);
    check("R9", "maj", o_maj, e_maj);
    check("R8", "w33", o_w33, e_w33);
    #(CLK_PERIOD/2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] cur;
    int sel;
    void'($urandom(32'h5eed_0007));
    #(CLK_PERIOD/2);
    // R5: reset state
    check("R5", "main_reset", o_main, 1'b0);
    apply(4'b1111, 1'b1);
    apply(4'b0000, 1'b0);
    // directed: partial arrival, rise, hold, release
    apply(4'b0010, 1'b0);   // R4 sum 1 below 2
    apply(4'b0110, 1'b0);   // R1 sum 2
    apply(4'b0100, 1'b0);   // R2 hold below threshold
    apply(4'b0000, 1'b0);   // R3 release
    apply(4'b0001, 1'b0);   // R1 weight-2 input alone; R8 partial
    apply(4'b0011, 1'b0);   // R8 rise, R6 rise
    apply(4'b0010, 1'b0);   // R6 hold, R8 hold
    apply(4'b0000, 1'b0);   // R6/R8 release
    apply(4'b0100, 1'b0);   // R9 one input only
    apply(4'b0101, 1'b0);   // R9 two inputs
    apply(4'b0001, 1'b0);   // R9 hold
    apply(4'b0000, 1'b0);
    apply(4'b1111, 1'b0);
    apply(4'b1111, 1'b1);   // R5 reset during DATA
    apply(4'b1000, 1'b0);   // release below threshold: stays NULL
    apply(4'b1010, 1'b0);
    apply(4'b0000, 1'b0);
    cur = 4'b0000;
    for (int k = 0; k < 3000; k++) begin
      sel = int'($urandom_range(0, 19));
      if (sel == 0) apply(cur, 1'b1);
      else begin
        if (sel < 3) cur = 4'b0000;
        else cur[$urandom_range(0, 3)] ^= 1'b1;
        apply(cur, 1'b0);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule